// File: doc/BRIEF.md
# Sliding Window Jet Finder

This block takes a rectangular grid of tower energies, one unsigned 8-bit value per tower, presented in parallel once per bunch crossing. It forms a region energy by summing each 2x2 block of towers at every position where such a block fits. A region becomes a jet candidate when its energy is a local maximum among the regions in the 5x5 block of region positions centred on it. For every candidate it forms a cluster energy by summing the 4x4 tower area that surrounds the candidate region.

The block compares each cluster energy with four programmable thresholds. For each threshold it reports how many candidates exceed it, and each count saturates. A trigger decision stage downstream reads these counts. The result comes out a fixed three clock cycles after the grid is presented and is marked by a one-cycle valid pulse. Grids may be presented on consecutive cycles.

Top module: `jet_window_finder`

## Requirements
- R1: Region (r,c) sums the towers in rows r and r+1 and columns c and c+1. With GRID_ROWS x GRID_COLS towers there are (GRID_ROWS-1) x (GRID_COLS-1) regions. Tower (r,c) is read from tower_i[(r*GRID_COLS+c)*8 +: 8].
- R2: A region is a candidate only if it beats every other region whose row and column offsets are each in -2..+2. A neighbour that comes earlier in raster order (a row above, or the same row and to the left) must be strictly smaller. A neighbour that comes later must be smaller or equal. A flat plateau therefore yields exactly one candidate, the first one in raster order.
- R3: A neighbour position outside the region grid compares as energy zero, so regions at the edge and in the corners can be candidates.
- R4: A region with zero energy is never a candidate.
- R5: The cluster energy of candidate (r,c) is the sum of the towers in rows r-1..r+2 and columns c-1..c+2. Towers outside the grid count as zero.
- R6: Count t is the number of candidates whose cluster energy is strictly greater than threshold t. Threshold t is taken from thresh_i[t*12 +: 12], and count t is driven on count_o[t*CNT_W +: CNT_W], for t = 0..3.
- R7: Each count saturates at 2^CNT_W-1, which is 7 by default.
- R8: Each cycle in which in_valid is high produces exactly one out_valid pulse three clock cycles later. The thresholds are sampled together with the grid. Back-to-back grids each produce their own result.
- R9: While reset is asserted, out_valid and all counts are zero. Between valid pulses the counts hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks a grid and a threshold set to process |
| tower_i | input | GRID_ROWS*GRID_COLS*TOWER_W | Tower energies, row-major |
| thresh_i | input | NUM_THR*(TOWER_W+4) | Cluster energy thresholds |
| out_valid | output | 1 | One-cycle pulse marking new counts |
| count_o | output | NUM_THR*CNT_W | Saturating candidate counts, one per threshold |

## Verification
The hardest condition to reach from the ports is count saturation. It needs eight or more candidates in one grid, and each of them must also pass the asymmetric tie-break against the others. Random sparse grids rarely get there. The stimulus therefore places isolated towers on a lattice of pitch three, with energies that rise in raster order, so that every hit wins against its earlier neighbours. Flat plateaus and corner hits are driven to exercise the tie-break and the zero border, and long runs of back-to-back random grids with idle gaps check alignment and hold behaviour.

// File: rtl/jf_pkg.sv
package jf_pkg;
  // Width of a 2x2 region sum for a given tower width
  function automatic int roi_width(input int tower_w);
    return tower_w + 2;
  endfunction

  // Width of a 4x4 cluster sum for a given tower width
  function automatic int cl_width(input int tower_w);
    return tower_w + 4;
  endfunction

  // Bits needed to hold a value up to n
  function automatic int tally_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/jf_window_sums.sv
module jf_window_sums #(
  parameter int GRID_ROWS = 8,
  parameter int GRID_COLS = 8,
  parameter int TOWER_W   = 8
) (
  input  logic [GRID_ROWS*GRID_COLS*TOWER_W-1:0]                          tower_i,
  output logic [(GRID_ROWS-1)*(GRID_COLS-1)*jf_pkg::roi_width(TOWER_W)-1:0] roi_o,
  output logic [(GRID_ROWS-1)*(GRID_COLS-1)*jf_pkg::cl_width(TOWER_W)-1:0]  cl_o
);
  localparam int REG_ROWS = GRID_ROWS - 1;
  localparam int REG_COLS = GRID_COLS - 1;
  localparam int ROI_W    = jf_pkg::roi_width(TOWER_W);
  localparam int CL_W     = jf_pkg::cl_width(TOWER_W);
  localparam int PAD_R    = GRID_ROWS + 2;
  localparam int PAD_C    = GRID_COLS + 2;

  // Tower grid with a one-tower ring of zeros around it
  logic [TOWER_W-1:0] tpad [PAD_R][PAD_C];

  for (genvar pr = 0; pr < PAD_R; pr++) begin : g_pad_r
    for (genvar pc = 0; pc < PAD_C; pc++) begin : g_pad_c
      if (pr >= 1 && pr <= GRID_ROWS && pc >= 1 && pc <= GRID_COLS) begin : g_in
        assign tpad[pr][pc] = tower_i[((pr-1)*GRID_COLS + (pc-1))*TOWER_W +: TOWER_W];
      end else begin : g_out
        assign tpad[pr][pc] = '0;
      end
    end
  end

  for (genvar r = 0; r < REG_ROWS; r++) begin : g_reg_r
    for (genvar c = 0; c < REG_COLS; c++) begin : g_reg_c
      logic [CL_W-1:0] acc;

      // 2x2 region: towers (r..r+1, c..c+1) sit at padded (r+1..r+2, c+1..c+2)
      assign roi_o[(r*REG_COLS + c)*ROI_W +: ROI_W] =
          ROI_W'(tpad[r+1][c+1]) + ROI_W'(tpad[r+1][c+2]) +
          ROI_W'(tpad[r+2][c+1]) + ROI_W'(tpad[r+2][c+2]);

      // 4x4 cluster: towers (r-1..r+2, c-1..c+2) sit at padded (r..r+3, c..c+3)
      always_comb begin
        acc = '0;
        for (int dr = 0; dr < 4; dr++) begin
          for (int dc = 0; dc < 4; dc++) begin
            acc = acc + CL_W'(tpad[r+dr][c+dc]);
          end
        end
      end

      assign cl_o[(r*REG_COLS + c)*CL_W +: CL_W] = acc;
    end
  end
endmodule

// File: rtl/jf_peak_find.sv
module jf_peak_find #(
  parameter int REG_ROWS = 7,
  parameter int REG_COLS = 7,
  parameter int ROI_W    = 10
) (
  input  logic [REG_ROWS*REG_COLS*ROI_W-1:0] roi_i,
  output logic [REG_ROWS*REG_COLS-1:0]       peak_o
);
  localparam int PAD_R = REG_ROWS + 4;
  localparam int PAD_C = REG_COLS + 4;

  // Region grid with a two-region ring of zeros (off-grid neighbours are zero)
  logic [ROI_W-1:0] rpad [PAD_R][PAD_C];

  for (genvar pr = 0; pr < PAD_R; pr++) begin : g_pad_r
    for (genvar pc = 0; pc < PAD_C; pc++) begin : g_pad_c
      if (pr >= 2 && pr < REG_ROWS + 2 && pc >= 2 && pc < REG_COLS + 2) begin : g_in
        assign rpad[pr][pc] = roi_i[((pr-2)*REG_COLS + (pc-2))*ROI_W +: ROI_W];
      end else begin : g_out
        assign rpad[pr][pc] = '0;
      end
    end
  end

  for (genvar r = 0; r < REG_ROWS; r++) begin : g_r
    for (genvar c = 0; c < REG_COLS; c++) begin : g_c
      logic win;

      always_comb begin
        win = (rpad[r+2][c+2] != '0);
        for (int dr = -2; dr <= 2; dr++) begin
          for (int dc = -2; dc <= 2; dc++) begin
            if (dr < 0 || (dr == 0 && dc < 0)) begin
              // earlier in raster order: must be strictly beaten
              if (rpad[r+2][c+2] <= rpad[r+2+dr][c+2+dc]) win = 1'b0;
            end else if (dr != 0 || dc != 0) begin
              // later in raster order: a tie is allowed
              if (rpad[r+2][c+2] < rpad[r+2+dr][c+2+dc]) win = 1'b0;
            end
          end
        end
      end

      assign peak_o[r*REG_COLS + c] = win;
    end
  end
endmodule

// File: rtl/jf_thr_count.sv
module jf_thr_count #(
  parameter int NUM_REG = 49,
  parameter int CL_W    = 12,
  parameter int NUM_THR = 4,
  parameter int CNT_W   = 3
) (
  input  logic [NUM_REG-1:0]      peak_i,
  input  logic [NUM_REG*CL_W-1:0] cl_i,
  input  logic [NUM_THR*CL_W-1:0] thr_i,
  output logic [NUM_THR*CNT_W-1:0] cnt_o
);
  localparam int          SUM_W   = jf_pkg::tally_width(NUM_REG);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic [SUM_W-1:0] tally;

    always_comb begin
      tally = '0;
      for (int i = 0; i < NUM_REG; i++) begin
        if (peak_i[i] && (cl_i[i*CL_W +: CL_W] > thr_i[t*CL_W +: CL_W])) begin
          tally = tally + SUM_W'(1);
        end
      end
    end

    assign cnt_o[t*CNT_W +: CNT_W] = (32'(tally) > CNT_MAX) ? CNT_W'(CNT_MAX) : CNT_W'(tally);
  end
endmodule

// File: rtl/jet_window_finder.sv
module jet_window_finder #(
  parameter int GRID_ROWS = 8,
  parameter int GRID_COLS = 8,
  parameter int TOWER_W   = 8,
  parameter int NUM_THR   = 4,
  parameter int CNT_W     = 3
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        in_valid,
  input  logic [GRID_ROWS*GRID_COLS*TOWER_W-1:0]      tower_i,
  input  logic [NUM_THR*jf_pkg::cl_width(TOWER_W)-1:0] thresh_i,
  output logic                                        out_valid,
  output logic [NUM_THR*CNT_W-1:0]                    count_o
);
  localparam int REG_ROWS = GRID_ROWS - 1;
  localparam int REG_COLS = GRID_COLS - 1;
  localparam int NUM_REG  = REG_ROWS * REG_COLS;
  localparam int ROI_W    = jf_pkg::roi_width(TOWER_W);
  localparam int CL_W     = jf_pkg::cl_width(TOWER_W);
  localparam int GRID_B   = GRID_ROWS * GRID_COLS * TOWER_W;
  localparam int THR_B    = NUM_THR * CL_W;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Stage 1: captured grid and thresholds
  logic              s1_vld_q;
  logic [GRID_B-1:0] s1_tower_q;
  logic [THR_B-1:0]  s1_thr_q;
  // Stage 2: region and cluster sums
  logic                     s2_vld_q;
  logic [NUM_REG*ROI_W-1:0] s2_roi_q;
  logic [NUM_REG*CL_W-1:0]  s2_cl_q;
  logic [THR_B-1:0]         s2_thr_q;
  // Stage 3: counts
  logic                     s3_vld_q;
  logic [NUM_THR*CNT_W-1:0] s3_cnt_q;

  // Combinational results between stages
  logic [NUM_REG*ROI_W-1:0]  roi_w;
  logic [NUM_REG*CL_W-1:0]   cl_w;
  logic [NUM_REG-1:0]        peak_w;
  logic [NUM_THR*CNT_W-1:0]  cnt_w;

  // Next-state and enables
  logic s1_vld_d, s2_vld_d, s3_vld_d;
  logic s1_en, s2_en, s3_en;

  always_comb begin
    s1_vld_d = in_valid;
    s2_vld_d = s1_vld_q;
    s3_vld_d = s2_vld_q;
    s1_en    = in_valid;
    s2_en    = s1_vld_q;
    s3_en    = s2_vld_q;
  end

  jf_window_sums #(
    .GRID_ROWS(GRID_ROWS),
    .GRID_COLS(GRID_COLS),
    .TOWER_W  (TOWER_W)
  ) u_sums (
    .tower_i(s1_tower_q),
    .roi_o  (roi_w),
    .cl_o   (cl_w)
  );

  jf_peak_find #(
    .REG_ROWS(REG_ROWS),
    .REG_COLS(REG_COLS),
    .ROI_W   (ROI_W)
  ) u_peak (
    .roi_i (s2_roi_q),
    .peak_o(peak_w)
  );

  jf_thr_count #(
    .NUM_REG(NUM_REG),
    .CL_W   (CL_W),
    .NUM_THR(NUM_THR),
    .CNT_W  (CNT_W)
  ) u_count (
    .peak_i(peak_w),
    .cl_i  (s2_cl_q),
    .thr_i (s2_thr_q),
    .cnt_o (cnt_w)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld_q   <= 1'b0;
      s1_tower_q <= '0;
      s1_thr_q   <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      if (s1_en) begin
        s1_tower_q <= tower_i;
        s1_thr_q   <= thresh_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_vld_q <= 1'b0;
      s2_roi_q <= '0;
      s2_cl_q  <= '0;
      s2_thr_q <= '0;
    end else begin
      s2_vld_q <= s2_vld_d;
      if (s2_en) begin
        s2_roi_q <= roi_w;
        s2_cl_q  <= cl_w;
        s2_thr_q <= s1_thr_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s3_vld_q <= 1'b0;
      s3_cnt_q <= '0;
    end else begin
      s3_vld_q <= s3_vld_d;
      if (s3_en) s3_cnt_q <= cnt_w;
    end
  end

  assign out_valid = s3_vld_q;
  assign count_o   = s3_cnt_q;
endmodule

// File: rtl/jf_checker.sv
module jf_checker #(
  parameter int NUM_THR  = 4,
  parameter int CNT_W    = 3,
  parameter int REG_ROWS = 7,
  parameter int REG_COLS = 7,
  parameter int ROI_W    = 10
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             in_valid,
  input logic                             out_valid,
  input logic [NUM_THR*CNT_W-1:0]         count_o,
  input logic [REG_ROWS*REG_COLS-1:0]     peak,
  input logic [REG_ROWS*REG_COLS*ROI_W-1:0] roi
);
  localparam int NUM_REG = REG_ROWS * REG_COLS;

  logic [2:0] vld_hist_q;
  logic       clash;
  logic       zero_peak;
  int         npeaks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_hist_q <= '0;
    else        vld_hist_q <= {vld_hist_q[1:0], in_valid};
  end

  // Two candidates closer than three region positions in both axes
  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NUM_REG; i++) begin
      for (int j = 0; j < NUM_REG; j++) begin
        if (i != j && peak[i] && peak[j] &&
            (i / REG_COLS - j / REG_COLS) <= 2 && (j / REG_COLS - i / REG_COLS) <= 2 &&
            (i % REG_COLS - j % REG_COLS) <= 2 && (j % REG_COLS - i % REG_COLS) <= 2) begin
          clash = 1'b1;
        end
      end
    end
  end

  always_comb begin
    zero_peak = 1'b0;
    for (int i = 0; i < NUM_REG; i++) begin
      if (peak[i] && roi[i*ROI_W +: ROI_W] == '0) zero_peak = 1'b1;
    end
  end

  assign npeaks = $countones(peak);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_hist_q[2]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(count_o));

  assert_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clash);

  assert_zero_never_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_peak);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_bound
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(count_o[t*CNT_W +: CNT_W]) <= $past(npeaks)));
  end
endmodule

bind jet_window_finder jf_checker #(
  .NUM_THR (NUM_THR),
  .CNT_W   (CNT_W),
  .REG_ROWS(REG_ROWS),
  .REG_COLS(REG_COLS),
  .ROI_W   (ROI_W)
) u_jf_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .count_o  (count_o),
  .peak     (peak_w),
  .roi      (s2_roi_q)
);

// File: tb/tb_jet_window_finder.sv
`timescale 1ns/1ps
module tb_jet_window_finder;
  localparam int GR   = 8;
  localparam int GC   = 8;
  localparam int TW   = 8;
  localparam int NT   = 4;
  localparam int CW   = 3;
  localparam int CLW  = TW + 4;
  localparam int RR   = GR - 1;
  localparam int RC   = GC - 1;
  localparam int SATV = (1 << CW) - 1;
  localparam int GB   = GR * GC * TW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [GB-1:0]     tower_i;
  logic [NT*CLW-1:0] thresh_i;
  logic              out_valid;
  logic [NT*CW-1:0]  count_o;

  always #2.5 clk = ~clk;

  jet_window_finder #(
    .GRID_ROWS(GR), .GRID_COLS(GC), .TOWER_W(TW), .NUM_THR(NT), .CNT_W(CW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tower_i(tower_i),
    .thresh_i(thresh_i), .out_valid(out_valid), .count_o(count_o)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  // Expected-result pipeline
  bit               qv[$];
  logic [NT*CW-1:0] qc[$];
  string            qt[$];
  logic [NT*CW-1:0] last_cnt = '0;

  logic [GB-1:0]     g;
  logic [NT*CLW-1:0] th;

  // Behavioural reference
  int m_tw  [GR][GC];
  int m_roi [RR][RC];

  function automatic int tw_at(input int r, input int c);
    if (r < 0 || r >= GR || c < 0 || c >= GC) return 0;
    return m_tw[r][c];
  endfunction

  function automatic int roi_at(input int r, input int c);
    if (r < 0 || r >= RR || c < 0 || c >= RC) return 0;
    return m_roi[r][c];
  endfunction

  function automatic logic [NT*CW-1:0] model(input logic [GB-1:0] grid, input logic [NT*CLW-1:0] thr);
    logic [NT*CW-1:0] res;
    int n [NT];
    for (int r = 0; r < GR; r++)
      for (int c = 0; c < GC; c++)
        m_tw[r][c] = int'(grid[(r*GC+c)*TW +: TW]);
    for (int r = 0; r < RR; r++)
      for (int c = 0; c < RC; c++)
        m_roi[r][c] = tw_at(r,c) + tw_at(r,c+1) + tw_at(r+1,c) + tw_at(r+1,c+1);
    for (int t = 0; t < NT; t++) n[t] = 0;
    for (int r = 0; r < RR; r++) begin
      for (int c = 0; c < RC; c++) begin
        bit ok;
        int cl;
        ok = (m_roi[r][c] != 0);
        for (int dr = -2; dr <= 2; dr++)
          for (int dc = -2; dc <= 2; dc++) begin
            if (dr < 0 || (dr == 0 && dc < 0)) begin
              if (!(m_roi[r][c] > roi_at(r+dr, c+dc))) ok = 1'b0;
            end else if (dr != 0 || dc != 0) begin
              if (m_roi[r][c] < roi_at(r+dr, c+dc)) ok = 1'b0;
            end
          end
        if (ok) begin
          cl = 0;
          for (int dr = -1; dr <= 2; dr++)
            for (int dc = -1; dc <= 2; dc++)
              cl += tw_at(r+dr, c+dc);
          for (int t = 0; t < NT; t++)
            if (cl > int'(thr[t*CLW +: CLW])) n[t]++;
        end
      end
    end
    for (int t = 0; t < NT; t++) res[t*CW +: CW] = CW'((n[t] > SATV) ? SATV : n[t]);
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic set_tower(input int r, input int c, input int v);
    g[(r*GC+c)*TW +: TW] = TW'(v);
  endtask

  task automatic set_thr(input int a, input int b, input int c, input int d);
    th = {CLW'(d), CLW'(c), CLW'(b), CLW'(a)};
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs
  task automatic step(input bit v, input string tag);
    bit               ev;
    logic [NT*CW-1:0] ec;
    string            et;
    @(negedge clk);
    ev = qv.pop_front();
    ec = qc.pop_front();
    et = qt.pop_front();
    check(out_valid == ev, "R8", "out_valid", int'(out_valid), int'(ev));
    for (int t = 0; t < NT; t++) begin
      if (ev)
        check(count_o[t*CW +: CW] == ec[t*CW +: CW], et, $sformatf("count%0d", t),
              int'(count_o[t*CW +: CW]), int'(ec[t*CW +: CW]));
      else
        check(count_o[t*CW +: CW] == last_cnt[t*CW +: CW], "R9", $sformatf("hold count%0d", t),
              int'(count_o[t*CW +: CW]), int'(last_cnt[t*CW +: CW]));
    end
    if (ev) last_cnt = ec;
    in_valid = v;
    tower_i  = g;
    thresh_i = th;
    qv.push_back(v);
    qc.push_back(v ? model(g, th) : '0);
    qt.push_back(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; tower_i = '0; thresh_i = '0;
    g = '0; th = '0;
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
      check(count_o == '0, "R9", "reset counts", int'(count_o), 0);
    end
    rst_n = 1'b1;
    repeat (3) begin qv.push_back(1'b0); qc.push_back('0); qt.push_back("R9"); end
    repeat (4) step(1'b0, "R9");

    // R4: empty grid produces no candidate
    g = '0; set_thr(0, 0, 0, 0);
    step(1'b1, "R4");

    // R1 R5 R6: lone tower, four regions tie, one cluster of 100
    g = '0; set_tower(3, 3, 100); set_thr(0, 50, 99, 100);
    step(1'b1, "R5");

    // R2: flat plateau of ones gives a single candidate with cluster 9
    g = '0;
    for (int r = 0; r < GR; r++) for (int c = 0; c < GC; c++) set_tower(r, c, 1);
    set_thr(0, 8, 9, 3);
    step(1'b1, "R2");

    // R3: corner towers make edge candidates
    g = '0; set_tower(0, 0, 50); set_tower(GR-1, GC-1, 60); set_thr(0, 50, 55, 59);
    step(1'b1, "R3");
    step(1'b0, "R9");

    // R7: nine separated candidates with rising energies saturate the low counts
    g = '0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        set_tower(1 + 3*i, 1 + 3*j, 100 + 10*(3*i + j));
    set_thr(0, 50, 135, 200);
    step(1'b1, "R7");
    set_thr(0, 0, 0, 0);
    step(1'b1, "R7");
    step(1'b0, "R9");

    // R6 R8: back-to-back random grids with idle gaps and fresh thresholds
    for (int k = 0; k < 400; k++) begin
      g = '0;
      for (int r = 0; r < GR; r++)
        for (int c = 0; c < GC; c++)
          if ($urandom_range(3) == 0) set_tower(r, c, int'($urandom_range(255, 1)));
      set_thr(int'($urandom_range(100)), int'($urandom_range(400)),
              int'($urandom_range(800)), int'($urandom_range(1500)));
      step($urandom_range(3) != 0, "R6");
    end

    repeat (5) step(1'b0, "R9");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule